// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a multi-cycle processor core for a small integer instruction subset: load word, store word, register add/subtract/and/or/set-less-than, add-immediate, branch-if-equal and jump-and-link. It holds a state machine that walks each instruction through a fixed series of cycles. From the current state and the instruction fields it produces the datapath controls: the immediate format, the two ALU operand selects, the result select, the memory address source, the ALU operation code, and the write strobes for the instruction register, PC, register file and memory.

Every output is a combinational function of the current state and the inputs `opcode_i`, `funct3_i`, `funct7_b5_i` and `zero_i`. The datapath is expected to hold the opcode and funct fields stable in its instruction register for the whole instruction. The fetch cycle computes PC+4 in the ALU and sends that result straight to the PC. The jump reuses the ALU writeback state to store its link value.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the state is Fetch and the outputs show Fetch values. This also applies when reset arrives partway through an instruction.
- R2: In Fetch the outputs are `opa_sel_o`=00, `opb_sel_o`=10, `res_sel_o`=10, `addr_sel_o`=0, `alu_op_o`=010, `ir_we_o`=1, `pc_we_o`=1, `rf_we_o`=0 and `mem_we_o`=0. The next state is always Decode.
- R3: In Decode the outputs are `opa_sel_o`=01, `opb_sel_o`=01, `res_sel_o`=00 and `alu_op_o`=010, with all four strobes low. Any opcode outside the supported set goes back to Fetch next, so it takes 2 cycles and asserts no write strobe.
- R4: Register ops (opcode 0110011) take 4 cycles. The execute cycle has `opa_sel_o`=10 and `opb_sel_o`=00. Its `alu_op_o` is set by funct3 and funct7 bit 5: 000 with bit 5 low gives 010, 000 with bit 5 high gives 110, 010 gives 111, 110 gives 001 and 111 gives 000. The writeback cycle has `rf_we_o`=1 and `res_sel_o`=00.
- R5: Add-immediate (opcode 0010011) takes 4 cycles. Its execute cycle has `opa_sel_o`=10, `opb_sel_o`=01 and `alu_op_o`=010 whatever the funct fields are. The ALU writeback cycle follows.
- R6: Load (opcode 0000011) takes 5 cycles. The address cycle has `opa_sel_o`=10, `opb_sel_o`=01 and `alu_op_o`=010. The read cycle has `addr_sel_o`=1. The load writeback cycle has `rf_we_o`=1 and `res_sel_o`=01.
- R7: Store (opcode 0100011) takes 4 cycles. The address cycle is the same as for a load. It is followed by a cycle with `addr_sel_o`=1 and `mem_we_o`=1. No other state asserts `mem_we_o`.
- R8: Branch (opcode 1100011) takes 3 cycles. Its third cycle has `opa_sel_o`=10, `opb_sel_o`=00 and `alu_op_o`=110, and `pc_we_o` equals `zero_i` in that cycle.
- R9: Jump (opcode 1101111) takes 4 cycles. The jump cycle has `opa_sel_o`=01, `opb_sel_o`=10, `res_sel_o`=00 and `pc_we_o`=1. The ALU writeback cycle follows.
- R10: `imm_fmt_o` depends only on the opcode, in every state. It is 00 for load and add-immediate, 01 for store, 10 for branch, 11 for jump, and 00 for any other opcode.
- R11: `alu_op_o` is 010 in every state other than the register execute cycle and the branch cycle. `zero_i` has no effect outside the branch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 7 | Instruction opcode field |
| funct3_i | input | 3 | Instruction funct3 field |
| funct7_b5_i | input | 1 | Bit 5 of the funct7 field |
| zero_i | input | 1 | ALU zero flag |
| imm_fmt_o | output | 2 | Immediate format select |
| opa_sel_o | output | 2 | ALU operand A select |
| opb_sel_o | output | 2 | ALU operand B select |
| res_sel_o | output | 2 | Result select |
| addr_sel_o | output | 1 | Memory address source select |
| alu_op_o | output | 3 | ALU operation code |
| ir_we_o | output | 1 | Instruction register write |
| pc_we_o | output | 1 | PC write |
| rf_we_o | output | 1 | Register file write |
| mem_we_o | output | 1 | Memory write |

## Verification
The outputs are combinational, so each one is due in the same cycle as the state and inputs it depends on. The state moves one step at each rising edge. The bench changes `zero_i` and the instruction fields at the falling edge, then compares 1 ns later, once per state of the instruction's expected path. Each path step is therefore checked exactly one clock after the previous one, and an instruction's cycle count is confirmed when the next Fetch shows up at the expected step. A reset asserted mid-instruction is checked 1 ns after it falls, without waiting for a clock edge.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int SEL_W = 2;
  localparam int ALU_W = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_BR    = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JMP   = 7'b1101111;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALU_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_W-1:0] ALU_SLT = 3'b111;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEM_ADDR, ST_MEM_RD, ST_MEM_WB, ST_MEM_WR,
    ST_EXEC_R, ST_EXEC_I, ST_ALU_WB, ST_BRANCH, ST_JUMP
  } ctrl_state_e;
endpackage

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_state_e      state_o
);
  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OPC_LOAD, OPC_STORE: state_d = ST_MEM_ADDR;
          OPC_REG:             state_d = ST_EXEC_R;
          OPC_IMM:             state_d = ST_EXEC_I;
          OPC_BR:              state_d = ST_BRANCH;
          OPC_JMP:             state_d = ST_JUMP;
          default:             state_d = ST_FETCH;
        endcase
      end
      ST_MEM_ADDR: state_d = (opcode_i == OPC_STORE) ? ST_MEM_WR : ST_MEM_RD;
      ST_MEM_RD:   state_d = ST_MEM_WB;
      ST_EXEC_R, ST_EXEC_I, ST_JUMP: state_d = ST_ALU_WB;
      default:     state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_ctrl_imm_dec.sv
module mc_ctrl_imm_dec
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [SEL_W-1:0] imm_fmt_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_STORE: imm_fmt_o = 2'b01;
      OPC_BR:    imm_fmt_o = 2'b10;
      OPC_JMP:   imm_fmt_o = 2'b11;
      default:   imm_fmt_o = 2'b00;  // I-type, and don't-care for others
    endcase
  end
endmodule

// File: rtl/mc_ctrl_alu_dec.sv
module mc_ctrl_alu_dec
  import mc_ctrl_pkg::*;
(
  input  logic [F3_W-1:0]  funct3_i,
  input  logic             funct7_b5_i,
  output logic [ALU_W-1:0] reg_op_o
);
  always_comb begin
    unique case (funct3_i)
      3'b000:  reg_op_o = funct7_b5_i ? ALU_SUB : ALU_ADD;
      3'b010:  reg_op_o = ALU_SLT;
      3'b110:  reg_op_o = ALU_OR;
      3'b111:  reg_op_o = ALU_AND;
      default: reg_op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  input  logic             funct7_b5_i,
  input  logic             zero_i,
  output logic [SEL_W-1:0] imm_fmt_o,
  output logic [SEL_W-1:0] opa_sel_o,
  output logic [SEL_W-1:0] opb_sel_o,
  output logic [SEL_W-1:0] res_sel_o,
  output logic             addr_sel_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             ir_we_o,
  output logic             pc_we_o,
  output logic             rf_we_o,
  output logic             mem_we_o
);
  ctrl_state_e      state;
  logic [ALU_W-1:0] reg_op;

  mc_ctrl_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opcode_i(opcode_i),
    .state_o (state)
  );

  mc_ctrl_imm_dec u_imm (
    .opcode_i (opcode_i),
    .imm_fmt_o(imm_fmt_o)
  );

  mc_ctrl_alu_dec u_alu (
    .funct3_i   (funct3_i),
    .funct7_b5_i(funct7_b5_i),
    .reg_op_o   (reg_op)
  );

  always_comb begin
    opa_sel_o  = 2'b00;
    opb_sel_o  = 2'b00;
    res_sel_o  = 2'b00;
    addr_sel_o = 1'b0;
    alu_op_o   = ALU_ADD;
    ir_we_o    = 1'b0;
    pc_we_o    = 1'b0;
    rf_we_o    = 1'b0;
    mem_we_o   = 1'b0;
    unique case (state)
      ST_FETCH: begin
        opb_sel_o = 2'b10;
        res_sel_o = 2'b10;  // ALU result straight to PC
        ir_we_o   = 1'b1;
        pc_we_o   = 1'b1;
      end
      ST_DECODE: begin
        opa_sel_o = 2'b01;
        opb_sel_o = 2'b01;
      end
      ST_EXEC_R: begin
        opa_sel_o = 2'b10;
        alu_op_o  = reg_op;
      end
      ST_EXEC_I, ST_MEM_ADDR: begin
        opa_sel_o = 2'b10;
        opb_sel_o = 2'b01;
      end
      ST_ALU_WB: rf_we_o = 1'b1;
      ST_MEM_RD: addr_sel_o = 1'b1;
      ST_MEM_WB: begin
        rf_we_o   = 1'b1;
        res_sel_o = 2'b01;
      end
      ST_MEM_WR: begin
        addr_sel_o = 1'b1;
        mem_we_o   = 1'b1;
      end
      ST_BRANCH: begin
        opa_sel_o = 2'b10;
        alu_op_o  = ALU_SUB;
        pc_we_o   = zero_i;
      end
      ST_JUMP: begin
        opa_sel_o = 2'b01;
        opb_sel_o = 2'b10;
        pc_we_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input ctrl_state_e      state,
  input logic [OPC_W-1:0] opcode_i,
  input logic [SEL_W-1:0] opb_sel_o,
  input logic [SEL_W-1:0] res_sel_o,
  input logic             addr_sel_o,
  input logic             ir_we_o,
  input logic             pc_we_o,
  input logic             rf_we_o,
  input logic             mem_we_o
);
  a_r7_store_uses_data_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> addr_sel_o);

  a_r2_fetch_drives_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we_o |-> (pc_we_o && opb_sel_o == 2'b10 && res_sel_o == 2'b10));

  a_r2_fetch_then_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we_o |=> (state == ST_DECODE && !ir_we_o && !pc_we_o && !rf_we_o && !mem_we_o));

  a_r3_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_we_o, rf_we_o, mem_we_o}));

  a_r6_read_then_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_MEM_RD |=> (rf_we_o && res_sel_o == 2'b01));

  a_r8_branch_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_BRANCH |=> state == ST_FETCH);

  a_r3_bad_opcode_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE && opcode_i == 7'b0000000) |=> ir_we_o);
endmodule

bind mc_ctrl mc_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state     (state),
  .opcode_i  (opcode_i),
  .opb_sel_o (opb_sel_o),
  .res_sel_o (res_sel_o),
  .addr_sel_o(addr_sel_o),
  .ir_we_o   (ir_we_o),
  .pc_we_o   (pc_we_o),
  .rf_we_o   (rf_we_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/mc_ctrl_test.sv
`timescale 1ns/1ps
module mc_ctrl_test;
  localparam int C_REG = 0, C_IMM = 1, C_LD = 2, C_ST = 3, C_BR = 4, C_JMP = 5, C_BAD = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] opcode_i = 7'b0;
  logic [2:0] funct3_i = 3'b0;
  logic       funct7_b5_i = 1'b0;
  logic       zero_i = 1'b0;
  logic [1:0] imm_fmt_o, opa_sel_o, opb_sel_o, res_sel_o;
  logic       addr_sel_o, ir_we_o, pc_we_o, rf_we_o, mem_we_o;
  logic [2:0] alu_op_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mc_ctrl uut (.*);

  function automatic int path_len(int c);
    case (c)
      C_LD:    return 5;
      C_BR:    return 3;
      C_BAD:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [6:0] opc_of(int c);
    case (c)
      C_REG:   return 7'b0110011;
      C_IMM:   return 7'b0010011;
      C_LD:    return 7'b0000011;
      C_ST:    return 7'b0100011;
      C_BR:    return 7'b1100011;
      C_JMP:   return 7'b1101111;
      default: begin
        case ($urandom_range(0, 3))
          0: return 7'b0000000;
          1: return 7'b1111111;
          2: return 7'b0110111;
          default: return 7'b1100111;
        endcase
      end
    endcase
  endfunction

  function automatic logic [1:0] ref_imm(int c);
    case (c)
      C_ST:    return 2'b01;
      C_BR:    return 2'b10;
      C_JMP:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [2:0] ref_reg_op(logic [2:0] f3, logic f7);
    case (f3)
      3'b000:  return f7 ? 3'b110 : 3'b010;
      3'b010:  return 3'b111;
      3'b110:  return 3'b001;
      3'b111:  return 3'b000;
      default: return 3'b010;
    endcase
  endfunction

  // {opa, opb, res, addr, ir, pc, rf, mem}
  function automatic logic [10:0] ref_ctl(int c, int k, logic z);
    logic [1:0] a, b, r;
    logic ad, ir, pc, rf, mw;
    a = 0; b = 0; r = 0; ad = 0; ir = 0; pc = 0; rf = 0; mw = 0;
    if (k == 0) begin b = 2; r = 2; ir = 1; pc = 1; end
    else if (k == 1) begin a = 1; b = 1; end
    else case (c)
      C_REG: if (k == 2) a = 2; else rf = 1;
      C_IMM: if (k == 2) begin a = 2; b = 1; end else rf = 1;
      C_LD:  if (k == 2) begin a = 2; b = 1; end
             else if (k == 3) ad = 1;
             else begin rf = 1; r = 1; end
      C_ST:  if (k == 2) begin a = 2; b = 1; end else begin ad = 1; mw = 1; end
      C_BR:  begin a = 2; pc = z; end
      C_JMP: if (k == 2) begin a = 1; b = 2; pc = 1; end else rf = 1;
      default: ;
    endcase
    return {a, b, r, ad, ir, pc, rf, mw};
  endfunction

  function automatic string req_of(int c, int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    case (c)
      C_REG: return "R4";
      C_IMM: return "R5";
      C_LD:  return "R6";
      C_ST:  return "R7";
      C_BR:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Checks the current cycle; caller is at a falling edge.
  task automatic check_step(int c, int k);
    logic [2:0] exp_alu;
    string rq;
    zero_i = 1'($urandom);
    #1;
    rq = req_of(c, k);
    cmp("R10", "imm_fmt", {14'b0, imm_fmt_o}, {14'b0, ref_imm(c)});
    cmp(rq, "controls",
        {5'b0, opa_sel_o, opb_sel_o, res_sel_o, addr_sel_o, ir_we_o, pc_we_o, rf_we_o, mem_we_o},
        {5'b0, ref_ctl(c, k, zero_i)});
    if (c == C_REG && k == 2)      begin exp_alu = ref_reg_op(funct3_i, funct7_b5_i); rq = "R4"; end
    else if (c == C_BR && k == 2)  begin exp_alu = 3'b110; rq = "R8"; end
    else                           begin exp_alu = 3'b010; rq = "R11"; end
    cmp(rq, "alu_op", {13'b0, alu_op_o}, {13'b0, exp_alu});
  endtask

  task automatic run_instr(int c, logic [2:0] f3, logic f7);
    opcode_i = opc_of(c);
    funct3_i = f3;
    funct7_b5_i = f7;
    for (int k = 0; k < path_len(c); k++) begin
      check_step(c, k);
      @(negedge clk_i);
    end
  endtask

  task automatic check_reset(string tag);
    cmp("R1", tag, {5'b0, opa_sel_o, opb_sel_o, res_sel_o, addr_sel_o, ir_we_o, pc_we_o, rf_we_o, mem_we_o},
        {5'b0, ref_ctl(C_REG, 0, 1'b0)});
  endtask

  function automatic logic [2:0] pick_reg_f3();
    case ($urandom_range(0, 3))
      0: return 3'b000;
      1: return 3'b010;
      2: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    #1 check_reset("reset_state");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed: every register op including sub (R4)
    run_instr(C_REG, 3'b000, 1'b0);
    run_instr(C_REG, 3'b000, 1'b1);
    run_instr(C_REG, 3'b010, 1'b1);
    run_instr(C_REG, 3'b110, 1'b0);
    run_instr(C_REG, 3'b111, 1'b0);
    // addi ignores funct7 even with sub pattern (R5)
    run_instr(C_IMM, 3'b000, 1'b1);
    run_instr(C_LD,  3'b010, 1'b0);
    run_instr(C_ST,  3'b010, 1'b0);
    run_instr(C_BR,  3'b000, 1'b0);
    run_instr(C_JMP, 3'b000, 1'b0);
    run_instr(C_BAD, 3'b000, 1'b0);

    // mid-instruction reset during a load (R1)
    opcode_i = 7'b0000011;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check_reset("mid_instr_reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int c;
      c = int'($urandom_range(0, 6));
      if (c == C_REG) run_instr(c, pick_reg_f3(), 1'($urandom));
      else            run_instr(c, 3'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule